// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block is the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it reads the register specifiers and control bits held in the decode, execute, memory and write-back pipeline registers. From them it produces the bypass selects for the two ALU operands, for the store-data operand and for the two inputs of the branch comparator in decode. It also produces the hold, squash, bubble and redirect controls for the front end.

Branches are compared in decode, and fetch continues down the sequential path until the outcome is known. A taken branch squashes the single wrong-path instruction and redirects the PC. When `UNIFIED_MEM` is 1, instructions and data share one memory port. A load or store in the memory stage then takes that port for the cycle, so the fetch slips by one cycle and a bubble enters decode. All outputs are combinational. `clk` and `rst_n` only time the embedded properties.

Top module: `hazard_interlock`

## Requirements
- R1: Each ALU operand select (`alu_a_sel`, `alu_b_sel`) is 2'b10 when the instruction in memory writes the operand's register, 2'b01 when only the instruction in write-back writes it, and 2'b00 otherwise. The memory stage wins when both write the register. The select is 2'b00 when the operand is unused.
- R2: When `ex_is_store` is 1, `store_sel` follows the R1 rule for `ex_rs2`. Otherwise it is 2'b00.
- R3: Register 0 never produces a non-zero select and never causes a hold or a bubble.
- R4: A producer that has already left write-back is read from the register file. A load in write-back feeds a decode branch with no stall and a comparator select of 2'b00.
- R5: A load in execute whose destination is a source used by decode raises `pc_hold`, `ifid_hold` and `idex_bubble` for that cycle.
- R6: A branch in decode stalls (`pc_hold`, `ifid_hold`, `idex_bubble`) when a source it uses is written by any register-writing instruction in execute or by a load in memory.
- R7: The branch comparator selects (`br_a_sel`, `br_b_sel`) are 2'b10 when a non-load instruction in memory writes the source, and 2'b00 otherwise.
- R8: A taken branch in decode that is not stalled raises `pc_redirect` and `ifid_squash`, and clears `pc_hold`.
- R9: With `UNIFIED_MEM`=1, a memory access in the memory stage raises `pc_hold` and `ifid_squash`, while decode still advances. With `UNIFIED_MEM`=0 the access has no effect on the front end.
- R10: When a data stall (R5 or R6) and a structural conflict coincide, the stall wins: `ifid_hold` is 1 and `ifid_squash` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the embedded properties |
| rst_n | input | 1 | Active-low reset that disables the properties |
| id_rs1 | input | AW | Decode source register 1 |
| id_rs2 | input | AW | Decode source register 2 |
| id_use1 | input | 1 | Decode reads source 1 |
| id_use2 | input | 1 | Decode reads source 2 |
| id_branch | input | 1 | Decode holds a conditional branch |
| id_taken | input | 1 | Comparator outcome for the branch in decode |
| ex_rs1 | input | AW | Execute source register 1 |
| ex_rs2 | input | AW | Execute source register 2 |
| ex_use1 | input | 1 | Execute reads source 1 |
| ex_use2 | input | 1 | Execute reads source 2 |
| ex_is_store | input | 1 | Execute holds a store (data comes from rs2) |
| ex_rd | input | AW | Execute destination register |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute holds a load |
| mem_rd | input | AW | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory stage holds a load |
| mem_access | input | 1 | Memory stage uses the data port (load or store) |
| wb_rd | input | AW | Write-back destination register |
| wb_wr | input | 1 | Write-back instruction writes a register |
| alu_a_sel | output | 2 | ALU operand A bypass select |
| alu_b_sel | output | 2 | ALU operand B bypass select |
| store_sel | output | 2 | Store-data bypass select |
| br_a_sel | output | 2 | Branch comparator input A select |
| br_b_sel | output | 2 | Branch comparator input B select |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_squash | output | 1 | Load a bubble into the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| pc_redirect | output | 1 | Load the branch target into the PC |

## Verification
The block holds no state, so any wrong decision shows at the ports in the same cycle its inputs arrive. A wrong select or control bit is therefore caught on that cycle's compare against the bench model, not cycles later. The compare model stresses a small register range so that destinations collide often, and it uses two instances so that the shared-port and split-port variants are checked on the same stimulus. The corners that matter are register 0, producers that collide in both stages, and a taken branch arriving together with a structural conflict.

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int AW = 5,
  parameter bit UNIFIED_MEM = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_branch,
  input  logic          id_taken,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic          ex_use1,
  input  logic          ex_use2,
  input  logic          ex_is_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_is_load,
  input  logic          mem_access,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output logic [1:0]    alu_a_sel,
  output logic [1:0]    alu_b_sel,
  output logic [1:0]    store_sel,
  output logic [1:0]    br_a_sel,
  output logic [1:0]    br_b_sel,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_squash,
  output logic          idex_bubble,
  output logic          pc_redirect
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [AW-1:0] R0 = '0;

  function automatic logic [1:0] ex_pick(input logic [AW-1:0] r, input logic u,
                                         input logic [AW-1:0] m_rd, input logic m_wr,
                                         input logic [AW-1:0] w_rd, input logic w_wr);
    if (!u || r == R0)          return SEL_RF;
    if (m_wr && m_rd == r)      return SEL_MEM;
    if (w_wr && w_rd == r)      return SEL_WB;
    return SEL_RF;
  endfunction

  assign alu_a_sel = ex_pick(ex_rs1, ex_use1, mem_rd, mem_wr, wb_rd, wb_wr);
  assign alu_b_sel = ex_pick(ex_rs2, ex_use2, mem_rd, mem_wr, wb_rd, wb_wr);
  assign store_sel = ex_pick(ex_rs2, ex_is_store, mem_rd, mem_wr, wb_rd, wb_wr);

  logic src1_live, src2_live;
  assign src1_live = id_use1 && id_rs1 != R0;
  assign src2_live = id_use2 && id_rs2 != R0;

  logic load_use, br_wait, data_stall, struct_hit, taken;

  assign load_use = ex_is_load &&
                    ((src1_live && id_rs1 == ex_rd) || (src2_live && id_rs2 == ex_rd));

  assign br_wait = id_branch &&
                   ((ex_wr && ((src1_live && id_rs1 == ex_rd) || (src2_live && id_rs2 == ex_rd))) ||
                    (mem_is_load && ((src1_live && id_rs1 == mem_rd) || (src2_live && id_rs2 == mem_rd))));

  assign br_a_sel = (id_branch && src1_live && mem_wr && !mem_is_load && mem_rd == id_rs1) ? SEL_MEM : SEL_RF;
  assign br_b_sel = (id_branch && src2_live && mem_wr && !mem_is_load && mem_rd == id_rs2) ? SEL_MEM : SEL_RF;

  assign data_stall = load_use || br_wait;
  assign struct_hit = UNIFIED_MEM && mem_access;
  assign taken      = id_branch && id_taken && !br_wait;

  assign pc_redirect = taken;
  assign pc_hold     = (data_stall || struct_hit) && !taken;
  assign ifid_hold   = data_stall;
  assign idex_bubble = data_stall;
  assign ifid_squash = !data_stall && (taken || struct_hit);

  // R5
  load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_rd != R0 && id_use1 && id_rs1 == ex_rd) |-> (pc_hold && ifid_hold && idex_bubble));

  // R8
  redirect_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> (ifid_squash && !pc_hold && !idex_bubble));

  // R10
  hold_beats_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold |-> !ifid_squash);

  // R3
  zero_reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == R0) |-> (alu_a_sel == SEL_RF));

  // R1
  mem_stage_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_use2 && ex_rs2 != R0 && mem_wr && mem_rd == ex_rs2) |-> (alu_b_sel == SEL_MEM));

  // R9
  split_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!UNIFIED_MEM && !id_branch && !ex_is_load) |-> !pc_hold);

endmodule

// File: tb/test_hazard_interlock.sv
module test_hazard_interlock;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use1, id_use2, id_branch, id_taken, ex_use1, ex_use2, ex_is_store;
  logic ex_wr, ex_is_load, mem_wr, mem_is_load, mem_access, wb_wr;

  logic [1:0] a_sel, b_sel, s_sel, ba_sel, bb_sel;
  logic pch, ifh, ifs, idb, red;
  logic [1:0] a2, b2, s2, ba2, bb2;
  logic pch2, ifh2, ifs2, idb2, red2;

  hazard_interlock #(.AW(AW), .UNIFIED_MEM(1'b1)) i_hazard_interlock (
    .clk, .rst_n, .id_rs1, .id_rs2, .id_use1, .id_use2, .id_branch, .id_taken,
    .ex_rs1, .ex_rs2, .ex_use1, .ex_use2, .ex_is_store, .ex_rd, .ex_wr, .ex_is_load,
    .mem_rd, .mem_wr, .mem_is_load, .mem_access, .wb_rd, .wb_wr,
    .alu_a_sel(a_sel), .alu_b_sel(b_sel), .store_sel(s_sel), .br_a_sel(ba_sel), .br_b_sel(bb_sel),
    .pc_hold(pch), .ifid_hold(ifh), .ifid_squash(ifs), .idex_bubble(idb), .pc_redirect(red));

  hazard_interlock #(.AW(AW), .UNIFIED_MEM(1'b0)) i_hazard_interlock_split (
    .clk, .rst_n, .id_rs1, .id_rs2, .id_use1, .id_use2, .id_branch, .id_taken,
    .ex_rs1, .ex_rs2, .ex_use1, .ex_use2, .ex_is_store, .ex_rd, .ex_wr, .ex_is_load,
    .mem_rd, .mem_wr, .mem_is_load, .mem_access, .wb_rd, .wb_wr,
    .alu_a_sel(a2), .alu_b_sel(b2), .store_sel(s2), .br_a_sel(ba2), .br_b_sel(bb2),
    .pc_hold(pch2), .ifid_hold(ifh2), .ifid_squash(ifs2), .idex_bubble(idb2), .pc_redirect(red2));

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: producers listed youngest first as (rd, writes, is_load)
  function automatic int ref_sel(input int r, input bit used);
    int rds[2]; bit wrs[2];
    rds[0] = mem_rd; wrs[0] = mem_wr;
    rds[1] = wb_rd;  wrs[1] = wb_wr;
    if (!used || r == 0) return 0;
    foreach (rds[k]) if (wrs[k] && rds[k] == r) return (k == 0) ? 2 : 1;
    return 0;
  endfunction

  task automatic compare_all;
    int srcs[2]; bit uses[2];
    bit lu, bw, ds, tk, st;
    int bs[2];
    srcs[0] = id_rs1; srcs[1] = id_rs2;
    uses[0] = id_use1; uses[1] = id_use2;
    lu = 0; bw = 0;
    for (int k = 0; k < 2; k++) begin
      bs[k] = 0;
      if (uses[k] && srcs[k] != 0) begin
        if (ex_is_load && ex_rd == srcs[k]) lu = 1;
        if (id_branch && ex_wr && ex_rd == srcs[k]) bw = 1;
        if (id_branch && mem_is_load && mem_rd == srcs[k]) bw = 1;
        if (id_branch && mem_wr && !mem_is_load && mem_rd == srcs[k]) bs[k] = 2;
      end
    end
    ds = lu | bw;
    tk = id_branch && id_taken && !bw;
    st = mem_access;
    chk("R1 alu_a", a_sel, ref_sel(ex_rs1, ex_use1));
    chk("R1 alu_b", b_sel, ref_sel(ex_rs2, ex_use2));
    chk("R2 store", s_sel, ref_sel(ex_rs2, ex_is_store));
    chk("R7 br_a", ba_sel, bs[0]);
    chk("R7 br_b", bb_sel, bs[1]);
    chk("R5/R6 idex_bubble", idb, ds);
    chk("R5/R6 ifid_hold", ifh, ds);
    chk("R8 redirect", red, tk);
    chk("R9 pc_hold", pch, (ds || st) && !tk);
    chk("R10 squash", ifs, !ds && (tk || st));
    chk("R9 split pc_hold", pch2, ds && !tk);
    chk("R9 split squash", ifs2, !ds && tk);
    chk("R9 split fwd", a2, a_sel);
  endtask

  task automatic idle;
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {id_use1, id_use2, id_branch, id_taken, ex_use1, ex_use2, ex_is_store} = '0;
    {ex_wr, ex_is_load, mem_wr, mem_is_load, mem_access, wb_wr} = '0;
  endtask

  task automatic step_check;
    @(negedge clk);
    compare_all();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk("reset pc_hold", pch, 0);
    chk("reset squash", ifs, 0);
    chk("reset alu_a", a_sel, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: both stages write r3 -> memory stage wins (2'b10)
    idle(); ex_rs1 = 3; ex_use1 = 1; mem_rd = 3; mem_wr = 1; wb_rd = 3; wb_wr = 1;
    @(negedge clk); chk("R1 priority", a_sel, 2); @(posedge clk); #1;
    // R4: only write-back writes -> 2'b01; beyond write-back -> 2'b00
    idle(); ex_rs2 = 4; ex_use2 = 1; wb_rd = 4; wb_wr = 1;
    @(negedge clk); chk("R1 wb fwd", b_sel, 1); @(posedge clk); #1;
    idle(); ex_rs2 = 4; ex_use2 = 1;
    @(negedge clk); chk("R4 regfile", b_sel, 0); @(posedge clk); #1;
    // R3: r0 never forwards nor stalls
    idle(); ex_use1 = 1; mem_wr = 1; id_use1 = 1; ex_is_load = 1; ex_wr = 1;
    @(negedge clk); chk("R3 alu_a", a_sel, 0); chk("R3 stall", pch, 0); @(posedge clk); #1;
    // R2: store data from load in write-back
    idle(); ex_is_store = 1; ex_rs2 = 6; wb_rd = 6; wb_wr = 1;
    @(negedge clk); chk("R2 store fwd", s_sel, 1); @(posedge clk); #1;
    // R5: load-use on source 2
    idle(); ex_is_load = 1; ex_wr = 1; ex_rd = 7; id_rs2 = 7; id_use2 = 1;
    @(negedge clk); chk("R5 bubble", idb, 1); chk("R5 pc_hold", pch2, 1); @(posedge clk); #1;
    // R6: branch behind ALU op in execute
    idle(); id_branch = 1; id_taken = 1; id_rs1 = 2; id_use1 = 1; ex_wr = 1; ex_rd = 2;
    @(negedge clk); chk("R6 stall", ifh, 1); chk("R6 no redirect", red, 0); @(posedge clk); #1;
    // R7: ALU result in memory feeds comparator; R8 taken
    idle(); id_branch = 1; id_taken = 1; id_rs1 = 2; id_use1 = 1; mem_wr = 1; mem_rd = 2;
    @(negedge clk); chk("R7 br fwd", ba_sel, 2); chk("R8 redirect", red, 1);
    chk("R8 squash", ifs, 1); chk("R8 no hold", pch, 0); @(posedge clk); #1;
    // R4: branch reads load in write-back without stall
    idle(); id_branch = 1; id_rs2 = 5; id_use2 = 1; wb_rd = 5; wb_wr = 1;
    @(negedge clk); chk("R4 br no stall", ifh, 0); chk("R4 br sel", bb_sel, 0); @(posedge clk); #1;
    // R9 / R10: structural conflict alone, then with load-use
    idle(); mem_access = 1;
    @(negedge clk); chk("R9 hold", pch, 1); chk("R9 squash", ifs, 1); chk("R9 split", pch2, 0); @(posedge clk); #1;
    idle(); mem_access = 1; ex_is_load = 1; ex_wr = 1; ex_rd = 1; id_rs1 = 1; id_use1 = 1;
    @(negedge clk); chk("R10 hold", ifh, 1); chk("R10 no squash", ifs, 0); @(posedge clk); #1;

    for (int i = 0; i < 3000; i++) begin
      id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
      ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
      ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      wb_rd = AW'($urandom_range(0, 3));
      id_use1 = 1'($urandom); id_use2 = 1'($urandom); id_branch = 1'($urandom);
      id_taken = 1'($urandom); ex_use1 = 1'($urandom); ex_use2 = 1'($urandom);
      ex_is_store = 1'($urandom); ex_is_load = 1'($urandom);
      ex_wr = ex_is_load | 1'($urandom);
      mem_is_load = 1'($urandom); mem_wr = mem_is_load | 1'($urandom);
      mem_access = mem_is_load | 1'($urandom); wb_wr = 1'($urandom);
      step_check();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule